// File: doc/BRIEF.md
# Configuration EEPROM Autoload Controller

After reset this block fetches the first thirteen 16-bit words of an external serial configuration EEPROM. It uses a four-wire, Microwire-style link: select, serial clock, command data out, read data in. The words are kept in a small store. From them the block derives the identification and power-management values that a host-bus configuration space would present.

Some fields are always taken from the EEPROM: the subsystem identifiers, the control byte and the 48-bit station address. The vendor ID, the device ID, the power-management capability dword and the new-capabilities flag are taken from the EEPROM only when enable patterns in word 4 match. When a pattern does not match, the parameterised defaults stay in place. All outputs show their defaults until the load-done flag rises. The flag stays high until the next reset, and no new read sequence starts before then.

Top module: `cfg_autoload`

## Requirements
- R1: After reset is released, words 0 to 12 are each read exactly once, in ascending address order. Each read begins with a 9-bit command sent MSB first on `ee_di_o`: start bit 1, opcode 2'b10, then the 6-bit word address. After load-done rises, select is never raised again.
- R2: While select is high, every high and low phase of the serial clock lasts exactly CLK_DIV clock cycles. `ee_di_o` does not change at a rising serial clock edge. The serial clock is low whenever select is low.
- R3: Read data is sampled MSB first at rising serial clock edges 10 to 25 of a transaction. Select drops at the falling edge that ends serial clock period 25. Select then stays low for CLK_DIV cycles before the next word.
- R4: `load_done_o` first reads high after the rising clock edge numbered 1 + 13*51*CLK_DIV, counted from reset release. It then stays high until reset.
- R5: While `load_done_o` is low, the outputs hold these values: vendor ID VID_DEFAULT, device ID DID_DEFAULT, capability PM_DEFAULT, new-capabilities NEWCAP_DEFAULT, and subsystem, control and station address all zero.
- R6: After load, `subsys_o` equals {word1, word0}: the subsystem ID is in bits 31:16 and the subsystem vendor ID is in bits 15:0.
- R7: After load, the vendor ID and device ID equal words 5 and 6 if word4[3:0] == 4'b1010. Otherwise they keep their defaults (1282h and 9102h).
- R8: After load, if word4[7] and word4[5] are both 1, the capability dword takes these values from word 7: bits 31:27 = w7[7:3], bit 21 = w7[2], bit 26 = w7[1], bit 25 = w7[0]. The new-capabilities flag then equals word4[0]. Otherwise the capability dword and the flag keep their defaults.
- R9: When the R8 pattern matches and word4[9] is 1, the capability dword also takes bits 18:16 = w4[12:10] and bits 24:22 = w4[15:13]. If word4[9] is 0, those bits stay at their default values.
- R10: After load, `ctrl_o` equals word7[15:8] and `mac_o` equals {word12, word11, word10}, without condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ee_cs_o | output | 1 | EEPROM select |
| ee_sclk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Command bits to EEPROM |
| ee_do_i | input | 1 | Read data from EEPROM |
| load_done_o | output | 1 | Load complete, sticky until reset |
| subsys_o | output | 32 | Subsystem ID and subsystem vendor ID |
| vendor_id_o | output | 16 | Vendor ID |
| device_id_o | output | 16 | Device ID |
| pm_cap_o | output | 32 | Power-management capability dword |
| new_cap_o | output | 1 | New-capabilities flag |
| ctrl_o | output | 8 | Control byte |
| mac_o | output | 48 | Station address |

## Verification
The bench builds the block with CLK_DIV = 2 and keeps 13 words and 6 address bits. This shortens a full load to about 1,300 cycles, so four complete loads fit in one run. Each load uses different word-4 patterns to cover these cases: both enables with the extension bit set, neither enable, the capability enable only, and the ID enable only. A short divider still gives two-cycle phases, so a phase length that is one cycle too long or too short shows up.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;
  typedef enum logic [1:0] {ST_START, ST_SHIFT, ST_GAP, ST_DONE} rd_state_e;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam int unsigned WORD_W = 16;
endpackage

// File: rtl/ee_word_reader.sv
module ee_word_reader
  import cfg_load_pkg::*;
#(
  parameter int unsigned CLK_DIV   = 4,
  parameter int unsigned NUM_WORDS = 13,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cs_o,
  output logic              sclk_o,
  output logic              di_o,
  input  logic              do_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_idx_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              done_o
);
  localparam int unsigned CMD_W = 3 + ADDR_W;
  localparam int unsigned TOT   = CMD_W + WORD_W;
  localparam int unsigned CNT_W = $clog2(CLK_DIV + 1);
  localparam int unsigned BIT_W = $clog2(TOT + 1);

  rd_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [ADDR_W-1:0] idx_q;
  logic [WORD_W-1:0] sh_q;
  logic [CMD_W-1:0]  cmd, cmd_sh;
  logic              tick, nxt_di;

  assign tick   = (cnt_q == CNT_W'(CLK_DIV - 1));
  assign cmd    = {1'b1, OP_READ, idx_q};
  assign cmd_sh = cmd << (bit_q + 1'b1);
  assign nxt_di = cmd_sh[CMD_W-1];   // zero once the command is exhausted

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_START;
      cnt_q   <= '0;
      bit_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      cs_o    <= 1'b0;
      sclk_o  <= 1'b0;
      di_o    <= 1'b0;
      wr_en_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      unique case (st_q)
        ST_START: begin
          st_q  <= ST_SHIFT;
          cs_o  <= 1'b1;
          di_o  <= 1'b1;
          bit_q <= '0;
          cnt_q <= '0;
        end
        ST_SHIFT: begin
          cnt_q <= tick ? '0 : cnt_q + 1'b1;
          if (tick) begin
            if (!sclk_o) begin
              sclk_o <= 1'b1;
              if (bit_q >= BIT_W'(CMD_W)) sh_q <= {sh_q[WORD_W-2:0], do_i};
            end else begin
              sclk_o <= 1'b0;
              if (bit_q == BIT_W'(TOT - 1)) begin
                cs_o    <= 1'b0;
                di_o    <= 1'b0;
                wr_en_o <= 1'b1;
                st_q    <= ST_GAP;
              end else begin
                bit_q <= bit_q + 1'b1;
                di_o  <= nxt_di;
              end
            end
          end
        end
        ST_GAP: begin
          cnt_q <= tick ? '0 : cnt_q + 1'b1;
          if (tick) begin
            if (idx_q == ADDR_W'(NUM_WORDS - 1)) begin
              st_q   <= ST_DONE;
              done_o <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_SHIFT;
              cs_o  <= 1'b1;
              di_o  <= 1'b1;
              bit_q <= '0;
            end
          end
        end
        default: ;  // ST_DONE: no restart before reset
      endcase
    end
  end

  assign wr_idx_o  = idx_q;
  assign wr_data_o = sh_q;
endmodule

// File: rtl/cfg_word_store.sv
module cfg_word_store
  import cfg_load_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 13,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_idx_i,
  input  logic [WORD_W-1:0]                 wr_data_i,
  output logic [NUM_WORDS-1:0][WORD_W-1:0]  words_o
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      words_o[g] <= '0;
      else if (wr_en_i && wr_idx_i == ADDR_W'(g))       words_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_load_pkg::*;
#(
  parameter int unsigned NUM_WORDS      = 13,
  parameter logic [15:0] VID_DEFAULT    = 16'h1282,
  parameter logic [15:0] DID_DEFAULT    = 16'h9102,
  parameter logic [31:0] PM_DEFAULT     = 32'h0002_0001,
  parameter logic        NEWCAP_DEFAULT = 1'b0
) (
  input  logic                             done_i,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] words_i,
  output logic [31:0]                      subsys_o,
  output logic [15:0]                      vendor_id_o,
  output logic [15:0]                      device_id_o,
  output logic [31:0]                      pm_cap_o,
  output logic                             new_cap_o,
  output logic [7:0]                       ctrl_o,
  output logic [47:0]                      mac_o
);
  logic [15:0] w4, w7;
  logic        id_en, pm_en;
  logic [31:0] pm;

  assign w4    = words_i[4];
  assign w7    = words_i[7];
  assign id_en = (w4[3:0] == 4'b1010);
  assign pm_en = w4[7] & w4[5];

  always_comb begin
    pm = PM_DEFAULT;
    if (pm_en) begin
      pm[31:27] = w7[7:3];
      pm[21]    = w7[2];
      pm[26]    = w7[1];
      pm[25]    = w7[0];
      if (w4[9]) begin
        pm[18:16] = w4[12:10];
        pm[24:22] = w4[15:13];
      end
    end
  end

  assign subsys_o    = done_i ? {words_i[1], words_i[0]} : '0;
  assign vendor_id_o = (done_i && id_en) ? words_i[5] : VID_DEFAULT;
  assign device_id_o = (done_i && id_en) ? words_i[6] : DID_DEFAULT;
  assign pm_cap_o    = done_i ? pm : PM_DEFAULT;
  assign new_cap_o   = (done_i && pm_en) ? w4[0] : NEWCAP_DEFAULT;
  assign ctrl_o      = done_i ? w7[15:8] : '0;
  assign mac_o       = done_i ? {words_i[12], words_i[11], words_i[10]} : '0;
endmodule

// File: rtl/cfg_autoload.sv
module cfg_autoload
  import cfg_load_pkg::*;
#(
  parameter int unsigned CLK_DIV        = 4,
  parameter int unsigned NUM_WORDS      = 13,
  parameter int unsigned ADDR_W         = 6,
  parameter logic [15:0] VID_DEFAULT    = 16'h1282,
  parameter logic [15:0] DID_DEFAULT    = 16'h9102,
  parameter logic [31:0] PM_DEFAULT     = 32'h0002_0001,
  parameter logic        NEWCAP_DEFAULT = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        ee_cs_o,
  output logic        ee_sclk_o,
  output logic        ee_di_o,
  input  logic        ee_do_i,
  output logic        load_done_o,
  output logic [31:0] subsys_o,
  output logic [15:0] vendor_id_o,
  output logic [15:0] device_id_o,
  output logic [31:0] pm_cap_o,
  output logic        new_cap_o,
  output logic [7:0]  ctrl_o,
  output logic [47:0] mac_o
);
  logic                             wr_en;
  logic [ADDR_W-1:0]                wr_idx;
  logic [WORD_W-1:0]                wr_data;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words;

  ee_word_reader #(.CLK_DIV(CLK_DIV), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_reader (
    .clk_i, .rst_ni,
    .cs_o(ee_cs_o), .sclk_o(ee_sclk_o), .di_o(ee_di_o), .do_i(ee_do_i),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .done_o(load_done_o)
  );

  cfg_word_store #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .words_o(words)
  );

  cfg_decode #(
    .NUM_WORDS(NUM_WORDS), .VID_DEFAULT(VID_DEFAULT), .DID_DEFAULT(DID_DEFAULT),
    .PM_DEFAULT(PM_DEFAULT), .NEWCAP_DEFAULT(NEWCAP_DEFAULT)
  ) u_decode (
    .done_i(load_done_o), .words_i(words),
    .subsys_o, .vendor_id_o, .device_id_o, .pm_cap_o, .new_cap_o, .ctrl_o, .mac_o
  );
endmodule

// File: rtl/cfg_autoload_chk.sv
module cfg_autoload_chk #(
  parameter logic [15:0] VID_DEFAULT    = 16'h1282,
  parameter logic [15:0] DID_DEFAULT    = 16'h9102,
  parameter logic [31:0] PM_DEFAULT     = 32'h0002_0001,
  parameter logic        NEWCAP_DEFAULT = 1'b0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ee_cs_o,
  input logic        ee_sclk_o,
  input logic        ee_di_o,
  input logic        load_done_o,
  input logic [15:0] vendor_id_o,
  input logic [15:0] device_id_o,
  input logic [31:0] pm_cap_o,
  input logic        new_cap_o,
  input logic [7:0]  ctrl_o,
  input logic [47:0] mac_o
);
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |=> load_done_o);  // R4
  AST_NO_CS_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_done_o |-> !ee_cs_o);  // R1
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ee_cs_o |-> !ee_sclk_o);  // R2
  AST_DI_STABLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ee_sclk_o) |-> $stable(ee_di_o));  // R2
  AST_DEFAULTS_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_done_o |-> (vendor_id_o == VID_DEFAULT && device_id_o == DID_DEFAULT &&
                      pm_cap_o == PM_DEFAULT && new_cap_o == NEWCAP_DEFAULT &&
                      ctrl_o == 8'h00 && mac_o == 48'h0));  // R5
endmodule

bind cfg_autoload cfg_autoload_chk #(
  .VID_DEFAULT(VID_DEFAULT), .DID_DEFAULT(DID_DEFAULT),
  .PM_DEFAULT(PM_DEFAULT), .NEWCAP_DEFAULT(NEWCAP_DEFAULT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ee_cs_o(ee_cs_o), .ee_sclk_o(ee_sclk_o),
  .ee_di_o(ee_di_o), .load_done_o(load_done_o), .vendor_id_o(vendor_id_o),
  .device_id_o(device_id_o), .pm_cap_o(pm_cap_o), .new_cap_o(new_cap_o),
  .ctrl_o(ctrl_o), .mac_o(mac_o)
);

// File: tb/cfg_autoload_bench.sv
`timescale 1ns/1ps
module cfg_autoload_bench;
  localparam int DIV = 2;
  localparam int NW  = 13;
  localparam int N_DONE = 1 + NW * 51 * DIV;
  localparam logic [31:0] PM_DEF = 32'h0002_0001;

  logic clk = 1'b0, rst_n = 1'b0, ee_do = 1'b0;
  logic cs, sclk, di, done, new_cap;
  logic [31:0] subsys, pm_cap;
  logic [15:0] vid, did;
  logic [7:0]  ctrl;
  logic [47:0] mac;

  always #2.5 clk = ~clk;

  cfg_autoload #(.CLK_DIV(DIV)) u_cfg_autoload (
    .clk_i(clk), .rst_ni(rst_n), .ee_cs_o(cs), .ee_sclk_o(sclk), .ee_di_o(di),
    .ee_do_i(ee_do), .load_done_o(done), .subsys_o(subsys), .vendor_id_o(vid),
    .device_id_o(did), .pm_cap_o(pm_cap), .new_cap_o(new_cap), .ctrl_o(ctrl), .mac_o(mac)
  );

  logic [15:0] mem [NW];
  int errors = 0, checks = 0;
  int cyc = 0, edge_n = 0, exp_addr = 0, run = 0, words_seen = 0;
  logic [8:0] cmd;
  logic [5:0] cur_addr;
  logic p_sclk = 1'b0, p_cs = 1'b0, active = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // EEPROM model
  always @(posedge cs) edge_n = 0;
  always @(posedge sclk) if (cs && active) begin
    edge_n++;
    if (edge_n <= 9) cmd = {cmd[7:0], di};
    if (edge_n == 9) begin
      cur_addr = cmd[5:0];
      chk(cmd == {1'b1, 2'b10, 6'(exp_addr)}, "R1 command", 64'(cmd), 64'({1'b1, 2'b10, 6'(exp_addr)}));
    end
  end
  always @(negedge sclk) if (cs && active && edge_n >= 9 && edge_n < 25)
    ee_do <= mem[cur_addr][15 - (edge_n - 9)];
  always @(negedge cs) if (active) begin
    chk(edge_n == 25, "R3 periods per word", 64'(edge_n), 64'd25);
    chk(exp_addr < NW, "R1 read count", 64'(exp_addr), 64'(NW - 1));
    exp_addr++;
    words_seen++;
  end

  always @(posedge clk) if (rst_n) cyc++;

  // per-cycle reference comparison
  always @(negedge clk) if (active && rst_n) begin
    logic e_done, id_en, pm_en;
    logic [31:0] e_pm;
    e_done = (cyc >= N_DONE);
    id_en  = (mem[4][3:0] == 4'b1010);
    pm_en  = mem[4][7] && mem[4][5];
    e_pm   = PM_DEF;
    if (e_done && pm_en) begin
      for (int b = 0; b < 5; b++) e_pm[27 + b] = mem[7][3 + b];
      e_pm[21] = mem[7][2]; e_pm[26] = mem[7][1]; e_pm[25] = mem[7][0];
      if (mem[4][9]) begin
        for (int b = 0; b < 3; b++) begin
          e_pm[16 + b] = mem[4][10 + b];
          e_pm[22 + b] = mem[4][13 + b];
        end
      end
    end
    chk(done == e_done, "R4 load_done", 64'(done), 64'(e_done));
    chk(subsys == (e_done ? {mem[1], mem[0]} : 32'h0), "R6/R5 subsys", 64'(subsys), 64'(e_done ? {mem[1], mem[0]} : 32'h0));
    chk(vid == ((e_done && id_en) ? mem[5] : 16'h1282), "R7/R5 vendor id", 64'(vid), 64'((e_done && id_en) ? mem[5] : 16'h1282));
    chk(did == ((e_done && id_en) ? mem[6] : 16'h9102), "R7/R5 device id", 64'(did), 64'((e_done && id_en) ? mem[6] : 16'h9102));
    chk(pm_cap == e_pm, "R8/R9 pm cap", 64'(pm_cap), 64'(e_pm));
    chk(new_cap == ((e_done && pm_en) ? mem[4][0] : 1'b0), "R8 new cap", 64'(new_cap), 64'((e_done && pm_en) ? mem[4][0] : 1'b0));
    chk(ctrl == (e_done ? mem[7][15:8] : 8'h0), "R10 ctrl", 64'(ctrl), 64'(e_done ? mem[7][15:8] : 8'h0));
    chk(mac == (e_done ? {mem[12], mem[11], mem[10]} : 48'h0), "R10 mac", 64'(mac), 64'(e_done ? {mem[12], mem[11], mem[10]} : 48'h0));
    if (sclk != p_sclk) begin
      if (p_cs) chk(run == DIV, "R2 phase length", 64'(run), 64'(DIV));
      run = 1;
    end else if (cs != p_cs) begin
      if (cs && words_seen > 0) chk(run == DIV, "R3 gap length", 64'(run), 64'(DIV));
      run = 1;
    end else run++;
    if (!cs) chk(!sclk, "R2 sclk low when idle", 64'(sclk), 64'd0);
    p_sclk = sclk;
    p_cs = cs;
  end

  task automatic run_load(input logic [15:0] w4, input logic [15:0] w7, input int seed);
    for (int i = 0; i < NW; i++) mem[i] = 16'((i + 1) * 16'h1357 ^ (seed * 16'h2b1d));
    mem[4] = w4;
    mem[7] = w7;
    rst_n = 1'b0; active = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && cs == 1'b0 && vid == 16'h1282, "R5 reset state", 64'({done, cs, vid}), 64'({2'b00, 16'h1282}));
    cyc = 0; exp_addr = 0; words_seen = 0; run = 0; p_cs = 1'b0; p_sclk = 1'b0;
    active = 1'b1; rst_n = 1'b1;
    repeat (N_DONE + 200) @(negedge clk);
    chk(words_seen == NW, "R1 words read", 64'(words_seen), 64'(NW));
  endtask

  initial begin
    fork
      begin
        run_load(16'h76AA, 16'hC35A, 1);   // ID and PM enables, extension bit set
        run_load(16'h0055, 16'hFFFF, 2);   // no enable
        run_load(16'h00F1, 16'h81A5, 3);   // PM enable only, new-cap 1
        run_load(16'h0A0A, 16'h3C07, 4);   // ID enable only, bit9 without PM enable
      end
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule